// File: doc/BRIEF.md
# Bus Request Opportunity Monitor

This block is a synchronous observer for a bus shared by two masters, A and B. Each cycle it samples three single-bit signals: A holds the bus, B requests the bus, and B holds the bus. It checks one fairness rule. Once A is on the bus while B waits, A must not drop the bus and win it straight back before B has been served.

A watch window opens in any cycle where A holds the bus, B requests and B does not hold the bus. The window then stays open, without B having to keep requesting, for as long as B never holds the bus. The first cycle with B on the bus closes it. A later opening condition opens a fresh window, so every window is watched.

Inside a window, a cycle where A is off the bus followed at once by a cycle where A is back on it is a violation. The monitor pulses a violation output combinationally in the regain cycle. A sticky failure flag latches that pulse from the next cycle until reset.

Top module: `req_opp_monitor`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after reset, both the violation output and the failure flag are 0, and no window is open.
- R2: A release and regain of A with no window open (B never requested while A held the bus) produces no violation.
- R3: A cycle with A holding, B requesting and B holding does not open a window.
- R4: B holding the bus in any cycle closes the window. A release and regain that has a B-holding cycle on or between the release and the regain produces no violation.
- R5: Inside an open window, a cycle with A off the bus followed by a cycle with A on the bus (and B not on it) drives the violation output to 1 in that regain cycle only.
- R6: A release that lasts several cycles before the regain still produces one violation pulse, in the regain cycle.
- R7: The failure flag rises in the cycle after a violation pulse and stays 1 until reset.
- R8: After a window is closed by B holding, a new opening condition opens a new window that is checked in the same way.
- R9: A window stays open after a violation. An opening condition in the same cycle as a regain leaves the window open, so a further release and regain gives a further pulse.
- R10: A release that happens before the window's opening cycle does not count, even when the opening cycle is the regain itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_hold_i | input | 1 | Master A holds the bus |
| b_req_i | input | 1 | Master B requests the bus |
| b_hold_i | input | 1 | Master B holds the bus |
| viol_o | output | 1 | Combinational violation pulse in the regain cycle |
| fail_o | output | 1 | Sticky failure flag, cleared only by reset |

## Verification
The assertions check the output relationships on every cycle:
- A pulse only appears with A on the bus, B off it, and A off the bus in the cycle before.
- A pulse is always followed by the failure flag.
- The failure flag never drops without reset.
- Reset clears the flag.

Whether a pulse fires at all depends on window history: where the window opened, whether B held the bus at some point inside it, and whether a release came before the opening. Only the bench's scenarios can show this, because they compare the output against hand-derived expectations.

// File: rtl/req_opp_pkg.sv
package req_opp_pkg;
  typedef struct packed {
    logic a_hold;
    logic b_req;
    logic b_hold;
  } bus_sample_t;
endpackage

// File: rtl/req_opp_window.sv
module req_opp_window
  import req_opp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  bus_sample_t smp,
  output logic        in_win
);
  logic armed_q;
  logic opens;

  // opening condition: A on the bus while B waits
  assign opens  = smp.a_hold & smp.b_req;
  // current cycle belongs to a window only while B stays off the bus
  assign in_win = ~smp.b_hold & (armed_q | opens);

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= in_win;
  end
endmodule

// File: rtl/req_opp_release.sv
module req_opp_release (
  input  logic clk,
  input  logic rst,
  input  logic in_win,
  input  logic a_hold,
  output logic regain
);
  logic rel_q;

  // a cycle of A off the bus inside a window, remembered for one cycle
  always_ff @(posedge clk) begin
    if (rst) rel_q <= 1'b0;
    else     rel_q <= in_win & ~a_hold;
  end

  assign regain = rel_q & in_win & a_hold;
endmodule

// File: rtl/req_opp_sticky.sv
module req_opp_sticky (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag | hit;
  end
endmodule

// File: rtl/req_opp_monitor.sv
module req_opp_monitor
  import req_opp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_hold_i,
  input  logic b_req_i,
  input  logic b_hold_i,
  output logic viol_o,
  output logic fail_o
);
  bus_sample_t smp;
  logic        in_win;
  logic        regain;

  assign smp = '{a_hold: a_hold_i, b_req: b_req_i, b_hold: b_hold_i};

  req_opp_window u_window (
    .clk    (clk),
    .rst    (rst),
    .smp    (smp),
    .in_win (in_win)
  );

  req_opp_release u_release (
    .clk    (clk),
    .rst    (rst),
    .in_win (in_win),
    .a_hold (a_hold_i),
    .regain (regain)
  );

  // mask the pulse while reset is clearing the stored state
  assign viol_o = regain & ~rst;

  req_opp_sticky u_sticky (
    .clk  (clk),
    .rst  (rst),
    .hit  (viol_o),
    .flag (fail_o)
  );
endmodule

// File: rtl/req_opp_monitor_chk.sv
module req_opp_monitor_chk (
  input logic clk,
  input logic rst,
  input logic a_hold_i,
  input logic b_hold_i,
  input logic viol_o,
  input logic fail_o
);
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !fail_o);

  assert_pulse_bus_state_R5: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> (a_hold_i && !b_hold_i));

  assert_pulse_after_release_R5: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> $past(!a_hold_i));

  assert_no_pulse_b_hold_R4: assert property (@(posedge clk) disable iff (rst)
    b_hold_i |-> !viol_o);

  assert_flag_follows_R7: assert property (@(posedge clk) disable iff (rst)
    viol_o |=> fail_o);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o);
endmodule

bind req_opp_monitor req_opp_monitor_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_hold_i (a_hold_i),
  .b_hold_i (b_hold_i),
  .viol_o   (viol_o),
  .fail_o   (fail_o)
);

// File: tb/tb_req_opp_monitor.sv
`timescale 1ns/1ps
module tb_req_opp_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_hold = 1'b0, b_req = 1'b0, b_hold = 1'b0;
  logic viol, fail;

  int tests  = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit exp_fail_q = 1'b0;

  typedef struct {
    bit    viol;
    bit    fail;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  req_opp_monitor dut (
    .clk      (clk),
    .rst      (rst),
    .a_hold_i (a_hold),
    .b_req_i  (b_req),
    .b_hold_i (b_hold),
    .viol_o   (viol),
    .fail_o   (fail)
  );

  // driver: one bus cycle and its expectation
  task automatic step(input bit a, input bit r, input bit h, input bit ev, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    a_hold = a; b_req = r; b_hold = h;
    e.viol = ev;
    e.fail = exp_fail_q;
    e.tag  = tag;
    sb.push_back(e);
    exp_fail_q = exp_fail_q | ev;
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst = 1'b1; a_hold = 1'b0; b_req = 1'b0; b_hold = 1'b0;
    @(posedge clk);
    #1;
    rst = 1'b0;
    exp_fail_q = 1'b0;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (viol !== e.viol || fail !== e.fail) begin
        errors++;
        $display("FAIL %s: viol=%0b fail=%0b expected viol=%0b fail=%0b",
                 e.tag, viol, fail, e.viol, e.fail);
      end
    end
  end

  initial begin
    do_reset();
    // R1 / R2: no window, release and regain ignored
    step(1,0,0,0,"R1");
    step(0,0,0,0,"R2");
    step(1,0,0,0,"R2");
    // R5 / R7
    step(1,1,0,0,"R5");
    step(0,0,0,0,"R5");
    step(1,0,0,1,"R5");
    step(1,0,0,0,"R7");
    step(1,0,0,0,"R7");
    do_reset();
    step(0,0,0,0,"R1");
    // R3
    step(1,1,1,0,"R3");
    step(0,0,0,0,"R3");
    step(1,0,0,0,"R3");
    // R4 regain cycle with B on the bus
    step(1,1,0,0,"R4");
    step(0,1,0,0,"R4");
    step(1,1,1,0,"R4");
    step(0,0,0,0,"R4");
    step(1,0,0,0,"R4");
    // R4 B holds between release and regain
    step(1,1,0,0,"R4");
    step(0,0,0,0,"R4");
    step(0,0,1,0,"R4");
    step(1,0,0,0,"R4");
    // R6 long release
    step(1,1,0,0,"R6");
    step(0,0,0,0,"R6");
    step(0,0,0,0,"R6");
    step(0,0,0,0,"R6");
    step(1,0,0,1,"R6");
    step(1,0,0,0,"R6");
    do_reset();
    // R8 reopen after close
    step(1,1,0,0,"R8");
    step(0,0,1,0,"R8");
    step(1,1,0,0,"R8");
    step(0,0,0,0,"R8");
    step(1,0,0,1,"R8");
    // R9 open on regain cycle, window persists
    step(0,1,0,0,"R9");
    step(1,1,0,1,"R9");
    step(0,0,0,0,"R9");
    step(1,0,0,1,"R9");
    step(1,0,0,0,"R9");
    do_reset();
    // R10 release before opening
    step(0,0,0,0,"R10");
    step(1,1,0,0,"R10");
    step(1,0,0,0,"R10");
    step(0,0,0,0,"R10");
    step(1,0,0,1,"R10");
    step(0,0,0,0,"R10");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      tests++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, errors);
      $finish;
    end
  end
endmodule